// File: doc/BRIEF.md
# Programmable counter array timebase

This block is the shared timebase of a programmable counter array. It holds one free-running 16-bit counter that the compare/capture modules watch, together with the mode and control registers that steer it. The counter advances on single-cycle count pulses taken from one of four sources: two prescaled taps of the block clock, the overflow pulse of a neighbouring timer, or a synchronised external count pin. Counting is gated by a run bit and, when the mode register selects it, by the idle-mode input.

When the counter wraps from all ones to zero it sets a sticky overflow flag. The block also keeps one sticky event flag per compare/capture module, set by a pulse from that module. Software reads and writes all state through a byte-wide register port with four addresses. A single interrupt request combines the overflow flag, gated by its enable, with the module event flags. The watchdog-enable bit is stored and driven out for the module that uses it.

Top module: `pca_timebase`

## Requirements
- R1: The source-select field (mode register bits 2:1) picks the count pulse: 00 one pulse every 12 clocks, 01 one pulse every 4 clocks, 10 each cycle of `tmr_ovf_i`, 11 each rising edge of the external pin; over any window of 48 enabled cycles the counter advances by exactly 4 with 00 and 12 with 01.
- R2: The counter changes only while the run bit (control register bit 6) is 1, apart from software writes to its bytes.
- R3: With the idle-stop bit (mode register bit 7) at 1, no counting takes place while `idle_i` is 1; with it at 0, `idle_i` has no effect on counting.
- R4: The external pin passes through a two-flop synchroniser, and each rising edge of the pin counts exactly once, however long the pin stays high; the pin may toggle at up to one-eighth of the clock rate.
- R5: A counted step from FFFFh wraps the counter to 0000h and sets the overflow flag (control register bit 7).
- R6: The overflow flag and the module event flags are sticky: they keep their value until software writes the control register; a written 0 clears a flag and a written 1 sets it.
- R7: `irq_o` is 1 whenever the overflow flag and the overflow interrupt enable (mode register bit 0) are both 1, or any module event flag is 1; otherwise it is 0.
- R8: A pulse on `mod_evt_i[n]` sets the event flag of module n, read at control register bit n (n = 0 to 4).
- R9: When hardware sets a flag in the same cycle as a software write of 0 to it, the flag ends up set.
- R10: After reset every register reads 00h; reserved bits (mode bits 5:3, control bit 5) always read 0; mode bit 6 is driven out on `wdt_en_o`.
- R11: The register map is address 0 mode, 1 control, 2 counter low byte, 3 counter high byte; both counter bytes are readable and writable, and a write to either byte takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (oscillator clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on `addr_i`) |
| idle_i | input | 1 | Chip idle-mode indication |
| tmr_ovf_i | input | 1 | Single-cycle overflow pulse of the neighbouring timer |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| mod_evt_i | input | 5 | Match/capture pulses of the compare/capture modules |
| irq_o | output | 1 | Interrupt request |
| wdt_en_o | output | 1 | Stored watchdog-enable bit |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, five module flags, prescaler taps of 12 and 4 and a two-stage pin synchroniser. Because the counter can be preloaded through the register port, the wrap from FFFFh and the overflow flag are reached within a few cycles rather than tens of thousands. Run windows are made a multiple of 12 clocks long, so the count gained from either prescaler tap is exact regardless of the free-running prescaler phase, and short windows near FFFFh place the wrap on a known tick.

// File: rtl/pca_pkg.sv
package pca_pkg;

  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned MOD_MAX  = 5;
  localparam int unsigned CNT_BASE = 2;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;

  // control register bit positions
  localparam int unsigned C_OVF = 7;
  localparam int unsigned C_RUN = 6;

  // mode register bit positions
  localparam int unsigned M_IDLE = 7;
  localparam int unsigned M_WDT  = 6;
  localparam int unsigned M_IE   = 0;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  typedef struct packed {
    logic idle_stop;
    logic wdt_en;
    src_e src;
    logic ovf_ie;
  } mode_t;

endpackage

// File: rtl/pca_divider.sv
module pca_divider #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/pca_pin_sync.sv
module pca_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned BASE   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);

  localparam int unsigned NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NB-1:0]    byte_we;
  logic             any_we;

  for (genvar b = 0; b < NB; b++) begin : g_bwe
    assign byte_we[b] = we_i && (addr_i == ADDR_W'(BASE + b));
  end

  assign any_we = |byte_we;

  always_comb begin
    cnt_d = cnt_q;
    if (any_we) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) cnt_d[b*8 +: 8] = wdata_i;
      end
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && !any_we && (&cnt_q);

endmodule

// File: rtl/pca_flags.sv
module pca_flags #(
  parameter int unsigned NUM_MOD = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               sw_ovf_i,
  input  logic               sw_run_i,
  input  logic [NUM_MOD-1:0] sw_evt_i,
  input  logic               wrap_i,
  input  logic [NUM_MOD-1:0] evt_i,
  output logic               ovf_o,
  output logic               run_o,
  output logic [NUM_MOD-1:0] evt_o
);

  logic ovf_q, run_q;

  // hardware set wins over a software write of 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      ovf_q <= wrap_i | (ctrl_we_i ? sw_ovf_i : ovf_q);
      if (ctrl_we_i) run_q <= sw_run_i;
    end
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_evt
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= evt_i[m] | (ctrl_we_i ? sw_evt_i[m] : flag_q);
    end
    assign evt_o[m] = flag_q;
  end

  assign ovf_o = ovf_q;
  assign run_o = run_q;

endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NUM_MOD     = 5,
  parameter int unsigned DIV_SLOW    = 12,
  parameter int unsigned DIV_FAST    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic               idle_i,
  input  logic               tmr_ovf_i,
  input  logic               cnt_pin_i,
  input  logic [NUM_MOD-1:0] mod_evt_i,
  output logic               irq_o,
  output logic               wdt_en_o
);

  localparam int unsigned NB = CNT_W / 8;

  mode_t            mode_q;
  logic             tick_slow, tick_fast, pin_rise;
  logic             src_tick, cnt_tick, wrap;
  logic             run_q, cf_q;
  logic [NUM_MOD-1:0] ccf_q;
  logic [CNT_W-1:0] cnt_val;
  logic             ctrl_we;
  logic [7:0]       ctrl_rd, mode_rd;

  // mode register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (we_i && addr_i == A_MODE) begin
      mode_q.idle_stop <= wdata_i[M_IDLE];
      mode_q.wdt_en    <= wdata_i[M_WDT];
      mode_q.src       <= src_e'(wdata_i[2:1]);
      mode_q.ovf_ie    <= wdata_i[M_IE];
    end
  end

  pca_divider #(.DIV(DIV_SLOW)) u_div_slow (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick_slow)
  );

  pca_divider #(.DIV(DIV_FAST)) u_div_fast (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick_fast)
  );

  pca_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (cnt_pin_i), .rise_o (pin_rise)
  );

  always_comb begin
    unique case (mode_q.src)
      SRC_SLOW: src_tick = tick_slow;
      SRC_FAST: src_tick = tick_fast;
      SRC_TMR:  src_tick = tmr_ovf_i;
      default:  src_tick = pin_rise;
    endcase
  end

  assign cnt_tick = run_q && !(mode_q.idle_stop && idle_i) && src_tick;

  pca_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE(CNT_BASE)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_tick),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_val),
    .wrap_o  (wrap)
  );

  assign ctrl_we = we_i && (addr_i == A_CTRL);

  pca_flags #(.NUM_MOD(NUM_MOD)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .sw_ovf_i  (wdata_i[C_OVF]),
    .sw_run_i  (wdata_i[C_RUN]),
    .sw_evt_i  (wdata_i[NUM_MOD-1:0]),
    .wrap_i    (wrap),
    .evt_i     (mod_evt_i),
    .ovf_o     (cf_q),
    .run_o     (run_q),
    .evt_o     (ccf_q)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[C_OVF]         = cf_q;
    ctrl_rd[C_RUN]         = run_q;
    ctrl_rd[NUM_MOD-1:0]   = ccf_q;
    mode_rd                = '0;
    mode_rd[M_IDLE]        = mode_q.idle_stop;
    mode_rd[M_WDT]         = mode_q.wdt_en;
    mode_rd[2:1]           = mode_q.src;
    mode_rd[M_IE]          = mode_q.ovf_ie;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MODE)      rdata_o = mode_rd;
    else if (addr_i == A_CTRL) rdata_o = ctrl_rd;
    else begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(CNT_BASE + b)) rdata_o = cnt_val[b*8 +: 8];
      end
    end
  end

  assign irq_o    = (cf_q && mode_q.ovf_ie) || (|ccf_q);
  assign wdt_en_o = mode_q.wdt_en;

endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_MOD = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic [NUM_MOD-1:0] mod_evt_i,
  input logic               irq_o,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               run_q,
  input logic               cf_q,
  input logic [NUM_MOD-1:0] ccf_q,
  input logic               cnt_tick,
  input logic               wrap
);

  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = we_i && addr_i[1];
  assign ctrl_wr = we_i && (addr_i == 2'd1);

  // R2
  a_r2_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_wr) |=> $stable(cnt_q));

  // R5
  a_r5_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && (&cnt_q) && !cnt_wr) |=> (cf_q && cnt_q == '0));

  // R6
  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_q && !ctrl_wr) |=> cf_q);

  // R6
  a_r6_evt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> ((ccf_q & $past(ccf_q)) == $past(ccf_q)));

  // R8
  a_r8_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mod_evt_i) |=> ((ccf_q & $past(mod_evt_i)) == $past(mod_evt_i)));

  // R7
  a_r7_evt_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ccf_q) |-> irq_o);

  // R9
  a_r9_hw_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && ctrl_wr && !wdata_i[7]) |=> cf_q);

  // R10
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[5:3] == 3'b000));

endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W), .NUM_MOD(NUM_MOD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .mod_evt_i (mod_evt_i),
  .irq_o     (irq_o),
  .cnt_q     (cnt_val),
  .run_q     (run_q),
  .cf_q      (cf_q),
  .ccf_q     (ccf_q),
  .cnt_tick  (cnt_tick),
  .wrap      (wrap)
);

// File: tb/tb_pca_timebase.sv
`timescale 1ns/1ps
module tb_pca_timebase;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       idle = 1'b0;
  logic       tmr = 1'b0;
  logic       pin = 1'b0;
  logic [4:0] evt = '0;
  logic       irq, wdt;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pca_timebase dut (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .idle_i (idle),
    .tmr_ovf_i (tmr), .cnt_pin_i (pin), .mod_evt_i (evt),
    .irq_o (irq), .wdt_en_o (wdt)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  logic  chk_req = 1'b0;

  // monitor: pops one expected item per request, compares away from the edge
  always @(negedge clk) begin
    if (chk_req) begin
      item_t      it;
      logic [7:0] obs;
      if (sb_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL [sb] empty queue: actual=0 expected=1");
      end else begin
        it = sb_q.pop_front();
        case (it.kind)
          0:       obs = rdata;
          1:       obs = {7'd0, irq};
          default: obs = {7'd0, wdt};
        endcase
        n_run++;
        if (obs !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, obs, it.exp);
        end
      end
    end
  end

  task automatic push_chk(input int k, input logic [7:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    addr = a;
    push_chk(0, e, t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    push_chk(1, {7'd0, e}, t);
  endtask

  task automatic chk_wdt(input logic e, input string t);
    push_chk(2, {7'd0, e}, t);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // run window of exactly 48 counting edges
  task automatic run48();
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h40);
    wait_cyc(47);
    wr(2'd1, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL [all] watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_cyc(1);

    // R10 reset state
    rd(2'd0, 8'h00, "R10 mode reset");
    rd(2'd1, 8'h00, "R10 ctrl reset");
    rd(2'd2, 8'h00, "R10 cnt lo reset");
    rd(2'd3, 8'h00, "R10 cnt hi reset");
    chk_irq(1'b0, "R7 irq reset");
    chk_wdt(1'b0, "R10 wdt reset");

    // R11 counter bytes
    wr(2'd2, 8'h34);
    wr(2'd3, 8'h12);
    rd(2'd2, 8'h34, "R11 cnt lo");
    rd(2'd3, 8'h12, "R11 cnt hi");

    // R2 run bit off: fast source, no count
    wr(2'd0, 8'h02);
    wait_cyc(40);
    rd(2'd2, 8'h34, "R2 stopped lo");
    rd(2'd3, 8'h12, "R2 stopped hi");

    // R1 fast and slow taps
    run48();
    rd(2'd2, 8'h0C, "R1 div4 count");
    wr(2'd0, 8'h00);
    run48();
    rd(2'd2, 8'h04, "R1 div12 count");
    rd(2'd1, 8'h00, "R2 run cleared");

    // R3 idle gating
    idle = 1'b1;
    wr(2'd0, 8'h82);
    run48();
    rd(2'd2, 8'h00, "R3 idle stops");
    wr(2'd0, 8'h02);
    run48();
    rd(2'd2, 8'h0C, "R3 idle ignored");
    idle = 1'b0;

    // R1 timer overflow source
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 5; i++) begin
      tmr = 1'b1;
      wait_cyc(1);
      tmr = 1'b0;
      wait_cyc(2);
    end
    wr(2'd1, 8'h00);
    rd(2'd2, 8'h05, "R1 timer source");

    // R4 external pin at one-eighth rate
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 6; i++) begin
      pin = 1'b1;
      wait_cyc(4);
      pin = 1'b0;
      wait_cyc(4);
    end
    wait_cyc(6);
    wr(2'd1, 8'h00);
    rd(2'd2, 8'h06, "R4 pin edges");

    // R5 wrap: FFFE + 2 fast ticks in 8 edges
    wr(2'd2, 8'hFE);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h40);
    wait_cyc(7);
    wr(2'd0, 8'h04);
    rd(2'd2, 8'h00, "R5 wrap lo");
    rd(2'd3, 8'h00, "R5 wrap hi");
    rd(2'd1, 8'hC0, "R5 ovf flag");
    chk_irq(1'b0, "R7 ovf masked");
    wait_cyc(20);
    rd(2'd1, 8'hC0, "R6 ovf sticky");
    wr(2'd0, 8'h05);
    chk_irq(1'b1, "R7 ovf enabled");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R6 ovf cleared");
    chk_irq(1'b0, "R7 irq dropped");
    wr(2'd1, 8'h80);
    rd(2'd1, 8'h80, "R6 ovf sw set");
    chk_irq(1'b1, "R7 irq sw set");
    wr(2'd1, 8'h00);

    // R8 module events
    wr(2'd0, 8'h04);
    evt = 5'b00100;
    wait_cyc(1);
    evt = '0;
    rd(2'd1, 8'h04, "R8 evt2 set");
    chk_irq(1'b1, "R7 evt irq");
    wait_cyc(10);
    rd(2'd1, 8'h04, "R6 evt sticky");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R6 evt cleared");
    chk_irq(1'b0, "R7 evt irq low");

    // R9 hardware set beats software clear
    evt = 5'b00010;
    wr(2'd1, 8'h00);
    evt = '0;
    rd(2'd1, 8'h02, "R9 hw wins");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R9 later clear");

    // R10 reserved bits and watchdog export
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'hC7, "R10 mode reserved");
    chk_wdt(1'b1, "R10 wdt out");
    wr(2'd1, 8'h20);
    rd(2'd1, 8'h00, "R10 ctrl reserved");
    wr(2'd0, 8'h00);
    chk_wdt(1'b0, "R10 wdt cleared");

    wait_cyc(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule